// File: doc/BRIEF.md
# Instruction Length Predecoder with Per-Line Tag Store

This block works out where instructions start and how many bytes the fetch stage must take. It runs on 16-byte instruction-cache lines that hold 16-bit parcels. Four encodings can be selected at run time. Each parcel is classified as the start of a 16-bit or a 32-bit instruction. It is also checked for a prefix or bundle marker, which means the instruction continues into the next 32-bit slot. The result is two tag bits per parcel. They are written into a small tag store that has one entry per cache set, when the line is refilled after a miss.

The fetch stage sends a set index, a parcel position and the line data read from the cache array. When the set's tags are valid, the block returns a fetch length code in the same cycle. When they are not valid, it raises a stall for that cycle. In the same cycle it rebuilds the tags from the supplied line, so a repeated request is served on the next cycle. Any change of the encoding mode invalidates every stored tag at once.

Top module: `ilen_predecoder`

## Requirements
- R1: In mode 0, a parcel starts a 32-bit instruction when bits[15:13]=111, or bits[15:12]=0111, or bits[15:12]=1001. Otherwise it is 16-bit.
- R2: In mode 0, the continuation flag is the OR of two terms. The prefix term is set when bits[15:9] are all ones. The bundle term is set when bits[15:12]=1111 with bit 10 set, or when bits[15:12]=1110 with bits 11 and 9 both set.
- R3: In mode 1, every even parcel is 32-bit. Its flag is set when bits[12:9]=1111, or when bit 12 and bit 10 are both set, or when bit 12 is clear and bits 11 and 9 are both set.
- R4: In mode 2, every even parcel is 32-bit. Its flag is set when bits[4:3]=11 and bits[1:0]=10, or when bits[6:0] are all ones. There is no bundle term.
- R5: In mode 3, a parcel (even or odd) is 32-bit when bits[1:0]=11. Its flag is set when bits[6:0] are all ones.
- R6: In modes 1 and 2, an odd parcel is never an instruction start. It reports as 16-bit with no flag, so the fetch length is 2 bytes.
- R7: fetch_len encoding: 0 means 2 bytes, 1 means 4 bytes, 2 means 8 bytes, 3 means 12 bytes. A 16-bit start gives 0. A 32-bit start without a flag gives 1. A flagged 32-bit start gives 2, or gives 3 when the parcel two positions later is still inside the line and is itself a flagged 32-bit start. No more than two flagged parcels are chained.
- R8: A fill writes the tags of the set it names. Parcel w of a line occupies bits [16w+15:16w]. A fetch of that set in any later cycle, in the same mode, is served with fetch_ok=1 and no stall.
- R9: A fetch of a set whose tags are invalid raises fetch_stall for exactly that cycle. It rebuilds the set's tags from fetch_line, so the same request in the next cycle, in an unchanged mode, is served. When a fill names the same set in the same cycle, the fill's line is the one stored.
- R10: A cycle in which isa_mode differs from the previous cycle invalidates every set. A fetch in that cycle stalls. Returning to an earlier mode restores no old tags.
- R11: After reset every set is invalid. fetch_ok and fetch_stall are both 0 while fetch_valid is 0. fetch_len is 0 whenever fetch_ok is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| isa_mode | input | 2 | Encoding mode 0..3 |
| fill_valid | input | 1 | Line refill this cycle |
| fill_set | input | SET_W | Set being refilled |
| fill_line | input | LINE_W | Refilled line data |
| fetch_valid | input | 1 | Fetch request |
| fetch_set | input | SET_W | Set of the fetched line |
| fetch_word | input | POS_W | Parcel position of the fetch address |
| fetch_line | input | LINE_W | Line data read from the cache array |
| fetch_stall | output | 1 | Tags invalid; request must be repeated |
| fetch_ok | output | 1 | Length is valid this cycle |
| fetch_len | output | 2 | Fetch length code |

## Verification
Each mode is tried with hand-built lines and with random lines. The hand-built lines place prefix and bundle patterns at every chain depth, including a flagged parcel near the line end where no room is left for a second link. This separates the 8-byte and 12-byte outcomes and catches any term of a mode's flag rule that is dropped. Odd and even positions are both fetched in every mode, which distinguishes the modes that reject odd parcels from the ones that accept them. A long random phase mixes fills, fetches of missing sets and mode switches. It separates a correct flush-and-rebuild sequence from one that keeps stale tags or stalls for the wrong number of cycles.

// File: rtl/ilen_pkg.sv
package ilen_pkg;

    typedef enum logic [1:0] {
        MODE_VAR16  = 2'd0,
        MODE_FIX32A = 2'd1,
        MODE_FIX32B = 2'd2,
        MODE_CMP    = 2'd3
    } isa_mode_e;

    typedef struct packed {
        logic is32;
        logic chain;
    } wtag_t;

    localparam logic [1:0] LEN_2B  = 2'd0;
    localparam logic [1:0] LEN_4B  = 2'd1;
    localparam logic [1:0] LEN_8B  = 2'd2;
    localparam logic [1:0] LEN_12B = 2'd3;

endpackage

// File: rtl/ilen_word_class.sv
module ilen_word_class
    import ilen_pkg::*;
(
    input  logic [15:0] word,
    input  logic        odd,
    input  isa_mode_e   mode,
    output wtag_t       tag
);

    logic pfx;
    logic bnd;

    always_comb begin
        tag = '0;
        pfx = 1'b0;
        bnd = 1'b0;
        case (mode)
            MODE_VAR16: begin
                tag.is32 = (word[15:13] == 3'b111) || (word[15:12] == 4'b0111) ||
                           (word[15:12] == 4'b1001);
                pfx = (word[15:9] == 7'h7F);
                bnd = ((word[15:12] == 4'hF) && word[10]) ||
                      ((word[15:12] == 4'hE) && word[11] && word[9]);
            end
            MODE_FIX32A: begin
                if (!odd) begin
                    tag.is32 = 1'b1;
                    pfx = (word[12:9] == 4'hF);
                    bnd = word[12] ? word[10] : (word[11] && word[9]);
                end
            end
            MODE_FIX32B: begin
                if (!odd) begin
                    tag.is32 = 1'b1;
                    pfx = ((word[4:3] == 2'b11) && (word[1:0] == 2'b10)) ||
                          (word[6:0] == 7'h7F);
                end
            end
            MODE_CMP: begin
                tag.is32 = (word[1:0] == 2'b11);
                pfx = (word[6:0] == 7'h7F);
            end
            default: tag = '0;
        endcase
        tag.chain = pfx || bnd;
    end

endmodule

// File: rtl/ilen_line_tagger.sv
module ilen_line_tagger
    import ilen_pkg::*;
#(
    parameter int WORDS = 8
)(
    input  logic [WORDS*16-1:0] line,
    input  isa_mode_e           mode,
    output logic [WORDS-1:0]    is32,
    output logic [WORDS-1:0]    chain
);

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        wtag_t t;
        ilen_word_class u_cls (
            .word (line[g*16 +: 16]),
            .odd  (1'(g % 2)),
            .mode (mode),
            .tag  (t)
        );
        assign is32[g]  = t.is32;
        assign chain[g] = t.chain;
    end

endmodule

// File: rtl/ilen_fetch_len.sv
module ilen_fetch_len
    import ilen_pkg::*;
#(
    parameter int WORDS = 8,
    localparam int POS_W = $clog2(WORDS)
)(
    input  logic [WORDS-1:0] is32,
    input  logic [WORDS-1:0] chain,
    input  logic [POS_W-1:0] pos,
    output logic [1:0]       len
);

    logic second;

    always_comb begin
        second = 1'b0;
        if (int'(pos) + 2 < WORDS) begin
            second = is32[int'(pos) + 2] && chain[int'(pos) + 2];
        end
        if (!is32[pos]) begin
            len = LEN_2B;
        end else if (!chain[pos]) begin
            len = LEN_4B;
        end else if (second) begin
            len = LEN_12B;
        end else begin
            len = LEN_8B;
        end
    end

endmodule

// File: rtl/ilen_predecoder.sv
module ilen_predecoder
    import ilen_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    parameter int NUM_SETS   = 4,
    localparam int WORDS  = LINE_BYTES / 2,
    localparam int POS_W  = $clog2(WORDS),
    localparam int SET_W  = $clog2(NUM_SETS),
    localparam int LINE_W = LINE_BYTES * 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        isa_mode,
    input  logic              fill_valid,
    input  logic [SET_W-1:0]  fill_set,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              fetch_valid,
    input  logic [SET_W-1:0]  fetch_set,
    input  logic [POS_W-1:0]  fetch_word,
    input  logic [LINE_W-1:0] fetch_line,
    output logic              fetch_stall,
    output logic              fetch_ok,
    output logic [1:0]        fetch_len
);

    typedef struct packed {
        logic [1:0]                      mode;
        logic [NUM_SETS-1:0]             vld;
        logic [NUM_SETS-1:0][WORDS-1:0]  is32;
        logic [NUM_SETS-1:0][WORDS-1:0]  chain;
    } state_t;

    state_t st_d, st_q;

    isa_mode_e        mode_e;
    logic [WORDS-1:0] fl_is32, fl_chain;
    logic [WORDS-1:0] rc_is32, rc_chain;
    logic [1:0]       sel_len;
    logic             flush;
    logic             hit;

    assign mode_e = isa_mode_e'(isa_mode);

    ilen_line_tagger #(.WORDS(WORDS)) u_fill_tag (
        .line  (fill_line),
        .mode  (mode_e),
        .is32  (fl_is32),
        .chain (fl_chain)
    );

    ilen_line_tagger #(.WORDS(WORDS)) u_fetch_tag (
        .line  (fetch_line),
        .mode  (mode_e),
        .is32  (rc_is32),
        .chain (rc_chain)
    );

    ilen_fetch_len #(.WORDS(WORDS)) u_len (
        .is32  (st_q.is32[fetch_set]),
        .chain (st_q.chain[fetch_set]),
        .pos   (fetch_word),
        .len   (sel_len)
    );

    always_comb begin
        st_d    = st_q;
        flush   = (isa_mode != st_q.mode);
        hit     = st_q.vld[fetch_set] && !flush;
        st_d.mode = isa_mode;
        if (flush) begin
            st_d.vld = '0;
        end
        if (fetch_valid && !hit) begin
            st_d.vld[fetch_set]   = 1'b1;
            st_d.is32[fetch_set]  = rc_is32;
            st_d.chain[fetch_set] = rc_chain;
        end
        if (fill_valid) begin
            st_d.vld[fill_set]   = 1'b1;
            st_d.is32[fill_set]  = fl_is32;
            st_d.chain[fill_set] = fl_chain;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_stall = fetch_valid && !hit;
    assign fetch_ok    = fetch_valid && hit;
    assign fetch_len   = fetch_ok ? sel_len : LEN_2B;

endmodule

// File: rtl/ilen_predecoder_chk.sv
module ilen_predecoder_chk #(
    parameter int LINE_BYTES = 16,
    parameter int NUM_SETS   = 4,
    localparam int WORDS = LINE_BYTES / 2,
    localparam int POS_W = $clog2(WORDS),
    localparam int SET_W = $clog2(NUM_SETS)
)(
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       isa_mode,
    input logic             fetch_valid,
    input logic [SET_W-1:0] fetch_set,
    input logic [POS_W-1:0] fetch_word,
    input logic             fetch_stall,
    input logic             fetch_ok,
    input logic [1:0]       fetch_len
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> (!fetch_ok && !fetch_stall)); // R11

    AST_OK_OR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> (fetch_ok != fetch_stall)); // R9

    AST_LEN_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_ok |-> (fetch_len == 2'd0)); // R11

    AST_STALL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |=> (!(fetch_valid && $stable(fetch_set) && $stable(isa_mode)) ||
                         !fetch_stall)); // R9

    AST_ODD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ok && fetch_word[0] && (isa_mode == 2'd1 || isa_mode == 2'd2))
            |-> (fetch_len == 2'd0)); // R6

    AST_FIXED_EVEN_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ok && !fetch_word[0] && (isa_mode == 2'd1 || isa_mode == 2'd2))
            |-> (fetch_len != 2'd0)); // R3

    AST_NO_CHAIN_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ok && (int'(fetch_word) + 2 >= WORDS)) |-> (fetch_len != 2'd3)); // R7

endmodule

bind ilen_predecoder ilen_predecoder_chk #(
    .LINE_BYTES (LINE_BYTES),
    .NUM_SETS   (NUM_SETS)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .isa_mode    (isa_mode),
    .fetch_valid (fetch_valid),
    .fetch_set   (fetch_set),
    .fetch_word  (fetch_word),
    .fetch_stall (fetch_stall),
    .fetch_ok    (fetch_ok),
    .fetch_len   (fetch_len)
);

// File: tb/test_ilen_predecoder.sv
module test_ilen_predecoder;

    localparam int LB = 16;
    localparam int NS = 4;
    localparam int NW = LB / 2;
    localparam int LW = LB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    isa_mode = 2'd0;
    logic          fill_valid = 1'b0;
    logic [1:0]    fill_set = '0;
    logic [LW-1:0] fill_line = '0;
    logic          fetch_valid = 1'b0;
    logic [1:0]    fetch_set = '0;
    logic [2:0]    fetch_word = '0;
    logic [LW-1:0] fetch_line = '0;
    logic          fetch_stall, fetch_ok;
    logic [1:0]    fetch_len;

    ilen_predecoder #(.LINE_BYTES(LB), .NUM_SETS(NS)) i_ilen_predecoder (.*);

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string cur_req = "R11";

    // reference state: stored line data per set, not tags
    logic [LW-1:0] m_line [NS];
    bit            m_vld  [NS];
    logic [1:0]    m_mode;

    function automatic void info(input logic [15:0] x, input int md, input bit odd,
                                 output bit wide, output bit fl);
        wide = 0; fl = 0;
        if (md == 0) begin
            wide = (x[15:12] ==? 4'b111?) || (x[15:12] == 4'h7) || (x[15:12] == 4'h9);
            fl = (x[15:9] == 7'b1111111) || (x[15:12] == 4'hF && x[10] == 1'b1) ||
                 (x[15:8] ==? 8'b11101?1?);
        end else if (md == 1 && !odd) begin
            wide = 1;
            fl = (x[12:9] == 4'b1111) || (x[12] && x[10]) || (!x[12] && (x[11:8] ==? 4'b1?1?));
        end else if (md == 2 && !odd) begin
            wide = 1;
            fl = (x[4:0] ==? 5'b11?10) || (x[6:0] == 7'b1111111);
        end else if (md == 3) begin
            wide = (x[1:0] == 2'b11);
            fl = (x[6:0] == 7'b1111111);
        end
    endfunction

    function automatic logic [1:0] ref_len(input logic [LW-1:0] ln, input int md, input int w);
        bit a32, af, b32, bf;
        info(ln[w*16 +: 16], md, bit'(w % 2), a32, af);
        if (!a32) return 2'd0;
        if (!af) return 2'd1;
        if (w + 2 < NW) begin
            info(ln[(w+2)*16 +: 16], md, bit'(w % 2), b32, bf);
            if (b32 && bf) return 2'd3;
        end
        return 2'd2;
    endfunction

    always @(negedge clk) begin
        bit fl, ht, e_ok, e_st;
        logic [1:0] e_len;
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
        if (!rst_n) begin
            e_ok = 0; e_st = 0; e_len = 0;
        end else begin
            fl = (isa_mode != m_mode);
            ht = m_vld[fetch_set] && !fl;
            e_ok = fetch_valid && ht;
            e_st = fetch_valid && !ht;
            e_len = e_ok ? ref_len(m_line[fetch_set], int'(isa_mode), int'(fetch_word)) : 2'd0;
        end
        checks++;
        if (fetch_ok !== e_ok || fetch_stall !== e_st || fetch_len !== e_len) begin
            failures++;
            $display("FAIL %s set=%0d word=%0d mode=%0d: ok/stall/len actual=%0b/%0b/%0d expected=%0b/%0b/%0d",
                     cur_req, fetch_set, fetch_word, isa_mode, fetch_ok, fetch_stall, fetch_len,
                     e_ok, e_st, e_len);
        end
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) m_vld[s] = 0;
            m_mode = 2'd0;
        end else begin
            if (fl) for (int s = 0; s < NS; s++) m_vld[s] = 0;
            if (fetch_valid && !ht) begin
                m_vld[fetch_set] = 1; m_line[fetch_set] = fetch_line;
            end
            if (fill_valid) begin
                m_vld[fill_set] = 1; m_line[fill_set] = fill_line;
            end
            m_mode = isa_mode;
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    function automatic logic [LW-1:0] rnd_line();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [LW-1:0] mk(input logic [15:0] w0, w1, w2, w3, w4, w5, w6, w7);
        return {w7, w6, w5, w4, w3, w2, w1, w0};
    endfunction

    task automatic fill(input int s, input logic [LW-1:0] ln);
        fill_valid = 1; fill_set = 2'(s); fill_line = ln;
        step();
        fill_valid = 0;
    endtask

    task automatic fetch_all(input int s);
        for (int w = 0; w < NW; w++) begin
            fetch_valid = 1; fetch_set = 2'(s); fetch_word = 3'(w); fetch_line = rnd_line();
            step();
        end
        fetch_valid = 0;
    endtask

    task automatic sweep(input int md, input string rq, input logic [LW-1:0] crafted);
        cur_req = "R10";
        isa_mode = 2'(md);
        fetch_valid = 1; fetch_set = 0; fetch_word = 0; fetch_line = crafted;
        step();                       // flush cycle: stall, rebuild from crafted
        fetch_valid = 0;
        cur_req = rq;
        for (int s = 1; s < NS; s++) fill(s, rnd_line());
        for (int s = 0; s < NS; s++) fetch_all(s);
    endtask

    initial begin
        repeat (3) step();
        cur_req = "R11";
        rst_n = 1;
        repeat (2) step();
        fetch_valid = 1; fetch_set = 2; fetch_word = 0; fetch_line = rnd_line();
        step();                       // invalid after reset: stall
        fetch_valid = 0;
        step();

        cur_req = "R1";
        fill(0, mk(16'hE000, 16'h7000, 16'h9000, 16'h1234, 16'h8000, 16'h6FFF, 16'hA5A5, 16'h0000));
        fetch_all(0);
        cur_req = "R2";
        fill(1, mk(16'hFE00, 16'h0000, 16'hFE00, 16'h0000, 16'hF400, 16'h0000, 16'hEA00, 16'hF400));
        fetch_all(1);
        cur_req = "R7";
        fill(2, mk(16'hE000, 16'hFE00, 16'hF400, 16'hEA00, 16'hE000, 16'hF000, 16'hFE00, 16'hFE00));
        fetch_all(2);
        sweep(0, "R1", rnd_line());

        sweep(1, "R3", mk(16'h1E00, 16'hFFFF, 16'h1400, 16'h0000, 16'h0A00, 16'h0000, 16'h1000, 16'h1E00));
        cur_req = "R6";
        fetch_all(0);
        sweep(2, "R4", mk(16'h001A, 16'h007F, 16'h007F, 16'h0000, 16'h0018, 16'h0000, 16'h001A, 16'h0000));
        cur_req = "R6";
        fetch_all(0);
        sweep(3, "R5", mk(16'h007F, 16'h007F, 16'h007F, 16'h007F, 16'h0003, 16'h0001, 16'h007F, 16'h0003));
        cur_req = "R7";
        fetch_all(0);

        cur_req = "R8";
        fill(3, rnd_line());
        fetch_all(3);

        cur_req = "R9";
        fetch_valid = 1; fetch_set = 1; fetch_word = 4; fetch_line = rnd_line();
        isa_mode = 2'd1;
        step();                       // flush + stall
        step();                       // same request now served
        fill_valid = 1; fill_set = 2; fill_line = rnd_line();
        fetch_set = 2; fetch_line = rnd_line();
        step();                       // miss with same-set fill: fill wins
        fill_valid = 0;
        step();
        fetch_valid = 0;

        cur_req = "R10";
        isa_mode = 2'd3; step();
        isa_mode = 2'd1; step();      // back to old mode: nothing restored
        fetch_all(1);

        cur_req = "R9";
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 40) == 0) isa_mode = 2'($urandom);
            fill_valid = ($urandom_range(0, 3) == 0);
            fill_set = 2'($urandom); fill_line = rnd_line();
            fetch_valid = ($urandom_range(0, 3) != 0);
            fetch_set = 2'($urandom); fetch_word = 3'($urandom); fetch_line = rnd_line();
            step();
        end
        fill_valid = 0; fetch_valid = 0;
        step();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule